// File: doc/BRIEF.md
# Masked Memory Barrier Ordering Gate

This unit sits between a core's in-order stream of memory requests and the memory port. Each request is a load, a store or a barrier. In every cycle the unit decides from its table of outstanding operations whether the request at the head of the stream may issue. A load or store that issues enters the table in the same cycle as its handshake. It leaves the table when the memory side reports its completion on a separate response port, tagged with the slot number the unit gave it at issue.

Loads and stores to different addresses move freely past each other. Two same-address cases always stay in order: a store behind an older store, and a store behind an older load. A barrier carries a four-bit mask. Each bit selects one older-kind to younger-kind ordering that must hold across the barrier. Two shorthand opcodes stand for the full barrier and the store-to-store barrier.

A barrier with a non-zero mask moves the fence state machine from `FS_OPEN` to `FS_HOLD` (transition "arm"). The operations outstanding at that moment are marked as older than the fence. While in `FS_HOLD`, any younger operation whose kind pair is selected by the mask waits behind those marked operations. The machine returns to `FS_OPEN` (transition "retire") in the first cycle in which no marked operation of a covered kind remains. A zero-mask barrier is accepted without leaving `FS_OPEN`.

Top module: `ord_gate`

## Requirements
- R1: After reset the table is empty, the fence machine is in `FS_OPEN`, and a load or a barrier presented is accepted at once; the first memory operation gets slot 0.
- R2: An issued load or store takes the lowest-numbered free slot, shown on `mem_id` during the handshake. With all `DEPTH` slots busy, loads and stores are held (`req_ready` low).
- R3: A completion (`cpl_valid` with `cpl_id`) frees that slot in the next cycle, and the slot can then be reused.
- R4: With no barrier in force, operations to different addresses never wait on each other. A load never waits on an older load or store to the same address.
- R5: A store waits while an older store or an older load to the same address is outstanding.
- R6: The barrier mask bit index is {younger is store, older is store}: bit 0 load to load, bit 1 store to load, bit 2 load to store, bit 3 store to store. A younger operation waits on a marked older operation exactly when the bit for that pair is set.
- R7: A barrier retires, and the machine returns to `FS_OPEN`, one cycle after no marked operation of a covered older kind remains. An older load is covered by bits 0 or 2, and an older store by bits 1 or 3. Operations issued after the barrier are not constrained by it.
- R8: A barrier whose mask is zero is accepted, never enters `FS_HOLD`, and constrains nothing.
- R9: Opcode 3 (full barrier) behaves as opcode 2 with mask 4'b1111, whatever `req_mask` holds.
- R10: Opcode 4 (store barrier) behaves as opcode 2 with mask 4'b1000, whatever `req_mask` holds.
- R11: While the machine is in `FS_HOLD`, a further barrier is held (`req_ready` low) until retirement.
- R12: Opcodes are 0 load, 1 store, 2 masked barrier. `mem_valid` is high only in a handshake of a load or store, with `mem_store` and `mem_addr` copied from the request.
- R13: Opcodes 5 to 7 are accepted at once and do nothing: no memory issue, no slot taken, no fence state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Request opcode |
| req_addr | input | AW | Request address |
| req_mask | input | 4 | Barrier ordering mask (opcode 2) |
| req_ready | output | 1 | Request accepted this cycle when valid |
| mem_valid | output | 1 | Memory operation issued to the port |
| mem_store | output | 1 | Issued operation is a store |
| mem_addr | output | AW | Issued operation address |
| mem_id | output | IDW | Slot given to the issued operation |
| cpl_valid | input | 1 | Completion report |
| cpl_id | input | IDW | Slot that completed |

## Verification
The assertions assume that the memory side only reports completions for slots that are currently outstanding, and never for the same slot twice. The bench's completion task only names slots it has seen issued and has not yet retired. Requests are changed on the falling edge and withdrawn before the next rising edge when only the ready decision is being probed, so nothing enters the table by accident.

// File: rtl/ord_pkg.sv
package ord_pkg;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_STORE   = 3'd1,
        OP_BAR     = 3'd2,
        OP_BAR_ALL = 3'd3,
        OP_BAR_ST  = 3'd4
    } op_e;

    typedef enum logic {
        FS_OPEN = 1'b0,
        FS_HOLD = 1'b1
    } fence_e;

    localparam logic [3:0] MASK_ALL = 4'b1111;
    localparam logic [3:0] MASK_ST  = 4'b1000;

endpackage

// File: rtl/ord_table.sv
module ord_table #(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    localparam int IDW  = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_en,
    input  logic                       alloc_store,
    input  logic [AW-1:0]              alloc_addr,
    input  logic                       mark_pre,
    input  logic                       cpl_valid,
    input  logic [IDW-1:0]             cpl_id,
    output logic [DEPTH-1:0]           ent_valid,
    output logic [DEPTH-1:0]           ent_store,
    output logic [DEPTH-1:0]           ent_pre,
    output logic [DEPTH-1:0][AW-1:0]   ent_addr,
    output logic [IDW-1:0]             free_id,
    output logic                       full
);

    always_comb begin
        free_id = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_id = IDW'(i);
        end
        full = &ent_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_store <= '0;
            ent_pre   <= '0;
            ent_addr  <= '0;
        end else begin
            if (mark_pre) ent_pre <= ent_valid;
            if (cpl_valid) begin
                ent_valid[cpl_id] <= 1'b0;
                ent_pre[cpl_id]   <= 1'b0;
            end
            if (alloc_en) begin
                ent_valid[free_id] <= 1'b1;
                ent_store[free_id] <= alloc_store;
                ent_addr[free_id]  <= alloc_addr;
                ent_pre[free_id]   <= 1'b0;
            end
        end
    end

    assert_cpl_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> ent_valid[cpl_id]);

    assert_alloc_slot_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> ent_valid[$past(free_id)]);

endmodule

// File: rtl/ord_hazard.sv
module ord_hazard #(
    parameter int DEPTH = 8,
    parameter int AW    = 8
) (
    input  logic [DEPTH-1:0]           ent_valid,
    input  logic [DEPTH-1:0]           ent_store,
    input  logic [DEPTH-1:0]           ent_pre,
    input  logic [DEPTH-1:0][AW-1:0]   ent_addr,
    input  logic                       hold,
    input  logic [3:0]                 fence_mask,
    input  logic                       in_store,
    input  logic [AW-1:0]              in_addr,
    output logic                       blocked,
    output logic                       fence_clear
);

    logic covers_ld;
    logic covers_st;

    always_comb begin
        covers_ld   = fence_mask[0] | fence_mask[2];
        covers_st   = fence_mask[1] | fence_mask[3];
        blocked     = 1'b0;
        fence_clear = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_valid[i] && in_store && ent_addr[i] == in_addr)
                blocked = 1'b1;
            if (hold && ent_valid[i] && ent_pre[i] && fence_mask[{in_store, ent_store[i]}])
                blocked = 1'b1;
            if (ent_valid[i] && ent_pre[i] && (ent_store[i] ? covers_st : covers_ld))
                fence_clear = 1'b0;
        end
    end

endmodule

// File: rtl/ord_fence_fsm.sv
module ord_fence_fsm
    import ord_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bar_take,
    input  logic [3:0] bar_mask,
    input  logic       fence_clear,
    output logic       hold,
    output logic       bar_open,
    output logic       mark_pre,
    output logic [3:0] mask_q
);

    fence_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_OPEN: if (bar_take && bar_mask != 4'b0) state_d = FS_HOLD;
            FS_HOLD: if (fence_clear) state_d = FS_OPEN;
            default: state_d = FS_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_OPEN;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FS_OPEN && bar_take) mask_q <= bar_mask;
        end
    end

    always_comb begin
        hold     = 1'b0;
        bar_open = 1'b0;
        mark_pre = 1'b0;
        unique case (state_q)
            FS_OPEN: begin
                bar_open = 1'b1;
                mark_pre = bar_take && bar_mask != 4'b0;
            end
            FS_HOLD: hold = 1'b1;
            default: bar_open = 1'b1;
        endcase
    end

    assert_arm_by_barrier_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(bar_take) && $past(bar_mask) != 4'b0);

    assert_no_bar_in_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !bar_take);

    assert_zero_mask_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && bar_take && bar_mask == 4'b0) |=> !hold);

endmodule

// File: rtl/ord_gate.sv
module ord_gate
    import ord_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    localparam int IDW  = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [2:0]     req_op,
    input  logic [AW-1:0]  req_addr,
    input  logic [3:0]     req_mask,
    output logic           req_ready,
    output logic           mem_valid,
    output logic           mem_store,
    output logic [AW-1:0]  mem_addr,
    output logic [IDW-1:0] mem_id,
    input  logic           cpl_valid,
    input  logic [IDW-1:0] cpl_id
);

    logic [DEPTH-1:0]         ent_valid;
    logic [DEPTH-1:0]         ent_store;
    logic [DEPTH-1:0]         ent_pre;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [IDW-1:0]           free_id;
    logic                     full;
    logic                     blocked;
    logic                     fence_clear;
    logic                     hold;
    logic                     bar_open;
    logic                     mark_pre;
    logic [3:0]               mask_q;
    logic                     is_mem;
    logic                     is_bar;
    logic                     is_store;
    logic [3:0]               eff_mask;
    logic                     bar_take;
    logic                     alloc_en;

    always_comb begin
        is_mem   = 1'b0;
        is_bar   = 1'b0;
        eff_mask = 4'b0;
        unique case (req_op)
            OP_LOAD, OP_STORE: is_mem = 1'b1;
            OP_BAR:     begin is_bar = 1'b1; eff_mask = req_mask; end
            OP_BAR_ALL: begin is_bar = 1'b1; eff_mask = MASK_ALL; end
            OP_BAR_ST:  begin is_bar = 1'b1; eff_mask = MASK_ST;  end
            default: ;
        endcase
        is_store = (req_op == OP_STORE);
        if (is_mem)      req_ready = !full && !blocked;
        else if (is_bar) req_ready = bar_open;
        else             req_ready = 1'b1;
        alloc_en  = req_valid && req_ready && is_mem;
        bar_take  = req_valid && req_ready && is_bar;
        mem_valid = alloc_en;
        mem_store = is_store;
        mem_addr  = req_addr;
        mem_id    = free_id;
    end

    ord_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (alloc_en),
        .alloc_store (is_store),
        .alloc_addr  (req_addr),
        .mark_pre    (mark_pre),
        .cpl_valid   (cpl_valid),
        .cpl_id      (cpl_id),
        .ent_valid   (ent_valid),
        .ent_store   (ent_store),
        .ent_pre     (ent_pre),
        .ent_addr    (ent_addr),
        .free_id     (free_id),
        .full        (full)
    );

    ord_hazard #(.DEPTH(DEPTH), .AW(AW)) u_hazard (
        .ent_valid   (ent_valid),
        .ent_store   (ent_store),
        .ent_pre     (ent_pre),
        .ent_addr    (ent_addr),
        .hold        (hold),
        .fence_mask  (mask_q),
        .in_store    (is_store),
        .in_addr     (req_addr),
        .blocked     (blocked),
        .fence_clear (fence_clear)
    );

    ord_fence_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bar_take    (bar_take),
        .bar_mask    (eff_mask),
        .fence_clear (fence_clear),
        .hold        (hold),
        .bar_open    (bar_open),
        .mark_pre    (mark_pre),
        .mask_q      (mask_q)
    );

    logic same_addr_live;
    logic fence_st_live;
    always_comb begin
        same_addr_live = 1'b0;
        fence_st_live  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_valid[i] && ent_addr[i] == mem_addr) same_addr_live = 1'b1;
            if (ent_valid[i] && ent_pre[i] && ent_store[i]) fence_st_live = 1'b1;
        end
    end

    assert_same_addr_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_store) |-> !same_addr_live);

    assert_fence_stst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && mask_q[3] && mem_valid && mem_store) |-> !fence_st_live);

    assert_no_issue_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !(&ent_valid));

endmodule

// File: tb/ord_gate_tb.sv
module ord_gate_tb;

    localparam int DEPTH = 8;
    localparam int AW    = 8;
    localparam int IDW   = $clog2(DEPTH);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [2:0]     req_op = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [3:0]     req_mask = '0;
    logic           req_ready;
    logic           mem_valid;
    logic           mem_store;
    logic [AW-1:0]  mem_addr;
    logic [IDW-1:0] mem_id;
    logic           cpl_valid = 1'b0;
    logic [IDW-1:0] cpl_id = '0;

    int checks = 0;
    int errors = 0;
    logic           s_ready;
    logic           s_mval;
    logic           s_mst;
    logic [AW-1:0]  s_maddr;
    logic [IDW-1:0] s_id;

    always #10 clk = ~clk;

    ord_gate #(.DEPTH(DEPTH), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_mask(req_mask), .req_ready(req_ready),
        .mem_valid(mem_valid), .mem_store(mem_store), .mem_addr(mem_addr),
        .mem_id(mem_id), .cpl_valid(cpl_valid), .cpl_id(cpl_id)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sample();
        s_ready = req_ready; s_mval = mem_valid; s_mst = mem_store;
        s_maddr = mem_addr;  s_id = mem_id;
    endtask

    // present a request for one cycle without letting it be taken
    task automatic probe(input logic [2:0] op, input logic [AW-1:0] a, input logic [3:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_mask = m;
        #1 sample();
        req_valid = 1'b0;
    endtask

    // present a request and let the next rising edge take it if ready
    task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [3:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_mask = m;
        #1 sample();
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic complete(input logic [IDW-1:0] id);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_id = id;
        @(posedge clk);
        #1 cpl_valid = 1'b0;
    endtask

    initial begin
        logic [3:0] mm;
        logic       covered;
        logic [2:0] bop;

        do_reset();
        // R1: empty after reset
        probe(3'd0, 8'h10, 4'h0);
        check("R1 load ready", s_ready, 1);
        check("R1 first slot", s_id, 0);
        probe(3'd2, 8'h00, 4'hF);
        check("R1 barrier ready", s_ready, 1);

        // R2/R12: fill all slots with loads
        for (int i = 0; i < DEPTH; i++) begin
            send(3'd0, 8'(8'h20 + i), 4'h0);
            check("R2 slot order", s_id, i);
            check("R12 mem_valid", s_mval, 1);
            check("R12 mem_addr", s_maddr, 32'(8'h20 + i));
            check("R12 mem_store", s_mst, 0);
        end
        probe(3'd1, 8'h77, 4'h0);
        check("R2 full holds store", s_ready, 0);
        check("R12 no issue when held", s_mval, 0);
        // R3: free slot 3, reuse it
        complete(3'd3);
        send(3'd1, 8'h44, 4'h0);
        check("R3 reuse slot", s_id, 3);
        check("R12 store flag", s_mst, 1);
        complete(3'd5);
        // R13: reserved opcodes
        for (int k = 5; k < 8; k++) begin
            probe(3'(k), 8'h01, 4'hF);
            check("R13 reserved accepted", s_ready, 1);
            check("R13 reserved no issue", s_mval, 0);
            send(3'(k), 8'h01, 4'hF);
        end
        send(3'd0, 8'h90, 4'h0);
        check("R13 no slot taken", s_id, 5);

        // R4/R5: same-address and different-address, no barrier
        for (int o = 0; o < 2; o++) begin
            for (int y = 0; y < 2; y++) begin
                do_reset();
                send(3'(o), 8'h05, 4'h0);
                probe(3'(y), 8'h05, 4'h0);
                check(y == 1 ? "R5 same addr store waits" : "R4 same addr load free",
                      s_ready, y == 1 ? 0 : 1);
                probe(3'(y), 8'h06, 4'h0);
                check("R4 different addr free", s_ready, 1);
                complete(3'd0);
                probe(3'(y), 8'h05, 4'h0);
                check("R5 released after completion", s_ready, 1);
            end
        end

        // R6/R7/R8/R11: every mask against every kind pair
        for (int o = 0; o < 2; o++) begin
            for (int y = 0; y < 2; y++) begin
                for (int m = 0; m < 16; m++) begin
                    mm = 4'(m);
                    covered = (o == 1) ? (mm[1] | mm[3]) : (mm[0] | mm[2]);
                    do_reset();
                    send(3'(o), 8'h01, 4'h0);
                    send(3'd2, 8'h00, mm);
                    probe(3'(y), 8'h02, 4'h0);
                    check(m == 0 ? "R8 zero mask free" : "R6 mask pair",
                          s_ready, mm[{y[0], o[0]}] ? 0 : 1);
                    probe(3'd2, 8'h00, 4'h1);
                    check("R11 barrier held while covered", s_ready, covered ? 0 : 1);
                    complete(3'd0);
                    probe(3'(y), 8'h02, 4'h0);
                    check("R7 released after older done", s_ready, 1);
                    probe(3'd2, 8'h00, 4'h1);
                    check("R7 fence retired", s_ready, 1);
                end
            end
        end

        // R7: ops after the barrier are not held by it
        do_reset();
        send(3'd1, 8'h01, 4'h0);
        send(3'd2, 8'h00, 4'b0100);
        send(3'd0, 8'h02, 4'h0);
        check("R7 younger load issues", s_ready, 1);
        probe(3'd1, 8'h03, 4'h0);
        check("R7 store not held by post-fence load", s_ready, 1);

        // R9/R10: shorthands ignore req_mask
        for (int o = 0; o < 2; o++) begin
            for (int y = 0; y < 2; y++) begin
                for (int s = 0; s < 2; s++) begin
                    bop = (s == 0) ? 3'd3 : 3'd4;
                    do_reset();
                    send(3'(o), 8'h01, 4'h0);
                    send(bop, 8'h00, (s == 0) ? 4'h0 : 4'h7);
                    probe(3'(y), 8'h02, 4'h0);
                    if (s == 0)
                        check("R9 full barrier", s_ready, 0);
                    else
                        check("R10 store barrier", s_ready, (o == 1 && y == 1) ? 0 : 1);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule